// File: doc/BRIEF.md
# Indexed Color Palette Host Port

This block holds a 256-entry table of 24-bit colors and gives a host a byte-wide, three-port register window onto it. The host first programs an index, then moves an entry's red, green and blue bytes one at a time through a shared data port. Reads and writes each have their own index and their own byte counter. After the third byte of an entry, the index advances on its own, so a whole table can be loaded or dumped with one index write followed by a stream of data accesses.

The port that takes the read index is write-only for that purpose. A host read of the same port returns a small state field instead. That field tells which of the two index registers was loaded last.

A select input redirects all data-port traffic to a separate 8-entry bank. The display side has one lookup port into the standard bank. It returns a pixel's color one clock after the pixel index is presented. An entry being loaded is written to storage only when its last byte arrives, so the display never sees a half-updated color.

Top module: `pal_dac_port`

## Requirements
- R1: After reset, both indices are 0, both byte counters point at red, the state field reads 0, `host_rdata` is 0, every entry of both banks is 0 and `pix_rgb` is 0.
- R2: A read of port 0 returns 8'h03 if the last index loaded was the read index (a write to port 0). It returns 8'h00 if the last index loaded was the write index (a write to port 1). Bits 7:2 always read 0.
- R3: Three writes to the data port (port 2) carry the red, green and blue bytes, in that order, of the entry at the write index. The entry is stored as {red, green, blue} in bits 23:0. The write index then advances by one.
- R4: A data-port write of red or green changes no stored entry. The whole entry is stored on the clock edge that takes the blue byte.
- R5: A read of the data port returns, one clock after the request, the red, then green, then blue byte of the entry at the read index. The read index then advances by one. A read of port 1 or port 3 returns 0.
- R6: A write to either index port restarts that index's byte sequence at red. Earlier partial bytes are discarded.
- R7: In the standard bank both indices wrap from 255 to 0.
- R8: While `pal_alt` is 1, data-port traffic uses the 8-entry alternate bank at the index's low 3 bits. On auto-advance only those 3 bits increment, modulo 8. The standard bank is left unchanged.
- R9: `pix_rgb` shows the standard-bank entry addressed by `pix_idx` one clock edge after `pix_idx` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe, one byte per cycle |
| host_addr | input | 2 | 0 read index / state, 1 write index, 2 data, 3 unused |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after `host_rd` |
| pal_alt | input | 1 | 1 selects the 8-entry alternate bank for data-port access |
| pix_idx | input | 8 | Pixel index for display lookup |
| pix_rgb | output | 24 | Standard-bank color {red, green, blue} for the previous `pix_idx` |

## Verification
The assertions assume that `host_wr` and `host_rd` are never high in the same cycle. They also assume that every index step they check comes from a completed three-byte sequence. The pixel-hold property takes for granted that the lookup output depends only on the pixel index and on entries stored in earlier cycles. The stimulus asserts one strobe per access and leaves an idle cycle after each one. It changes `pal_alt` and `pix_idx` only on the falling clock edge and only between accesses. As a result, no transfer straddles a bank switch.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

   localparam int BYTE_W  = 8;
   localparam int COMP_N  = 3;

   typedef enum logic [1:0] {
      PORT_RIDX = 2'd0,
      PORT_WIDX = 2'd1,
      PORT_DATA = 2'd2,
      PORT_NONE = 2'd3
   } port_e;

   typedef enum logic [1:0] {
      COMP_R = 2'd0,
      COMP_G = 2'd1,
      COMP_B = 2'd2,
      COMP_X = 2'd3
   } comp_e;

   localparam logic [1:0] LAST_WAS_WIDX = 2'b00;
   localparam logic [1:0] LAST_WAS_RIDX = 2'b11;

endpackage

// File: rtl/pal_index_seq.sv
`timescale 1ns/1ps
module pal_index_seq
   import pal_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int ALT_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   input  logic             alt,
   output logic [IDX_W-1:0] idx,
   output comp_e            comp
);

   logic [IDX_W-1:0] idx_next;
   logic [ALT_W-1:0] low_next;

   assign low_next = idx[ALT_W-1:0] + 1'b1;

   always_comb begin
      if (alt) idx_next = {idx[IDX_W-1:ALT_W], low_next};
      else     idx_next = idx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         comp <= COMP_R;
      end else if (load) begin
         idx  <= load_val;
         comp <= COMP_R;
      end else if (step) begin
         unique case (comp)
            COMP_R:  comp <= COMP_G;
            COMP_G:  comp <= COMP_B;
            default: begin
               comp <= COMP_R;
               idx  <= idx_next;
            end
         endcase
      end
   end

endmodule

// File: rtl/pal_stage.sv
`timescale 1ns/1ps
module pal_stage
   import pal_pkg::*;
(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  comp_e                      comp,
   input  logic [BYTE_W-1:0]          wdata,
   output logic                       commit,
   output logic [COMP_N*BYTE_W-1:0]   entry
);

   logic [BYTE_W-1:0] red_q;
   logic [BYTE_W-1:0] green_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         red_q   <= '0;
         green_q <= '0;
      end else if (wr_en) begin
         if (comp == COMP_R) red_q   <= wdata;
         if (comp == COMP_G) green_q <= wdata;
      end
   end

   assign commit = wr_en && (comp == COMP_B);
   assign entry  = {red_q, green_q, wdata};

endmodule

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store #(
   parameter int IDX_W   = 8,
   parameter int ALT_W   = 3,
   parameter int ENTRY_W = 24,
   parameter bit ALT_EN  = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic               walt,
   input  logic [IDX_W-1:0]   waddr,
   input  logic [ENTRY_W-1:0] wentry,
   input  logic               ralt,
   input  logic [IDX_W-1:0]   raddr,
   output logic [ENTRY_W-1:0] rentry,
   input  logic [IDX_W-1:0]   pix_idx,
   output logic [ENTRY_W-1:0] pix_rgb
);

   localparam int STD_DEPTH = 1 << IDX_W;
   localparam int ALT_DEPTH = 1 << ALT_W;

   logic [ENTRY_W-1:0] std_mem [STD_DEPTH];
   logic [ENTRY_W-1:0] alt_rd;
   logic               std_we;

   assign std_we = we && !walt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STD_DEPTH; i++) std_mem[i] <= '0;
      end else if (std_we) begin
         std_mem[waddr] <= wentry;
      end
   end

   generate
      if (ALT_EN) begin : g_alt
         logic [ENTRY_W-1:0] alt_mem [ALT_DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int j = 0; j < ALT_DEPTH; j++) alt_mem[j] <= '0;
            end else if (we && walt) begin
               alt_mem[waddr[ALT_W-1:0]] <= wentry;
            end
         end
         assign alt_rd = alt_mem[raddr[ALT_W-1:0]];
      end else begin : g_no_alt
         assign alt_rd = '0;
      end
   endgenerate

   assign rentry = ralt ? alt_rd : std_mem[raddr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_rgb <= '0;
      else        pix_rgb <= std_mem[pix_idx];
   end

endmodule

// File: rtl/pal_dac_port.sv
`timescale 1ns/1ps
module pal_dac_port
   import pal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int ALT_W  = 3,
   parameter bit ALT_EN = 1'b1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_wr,
   input  logic                      host_rd,
   input  logic [1:0]                host_addr,
   input  logic [BYTE_W-1:0]         host_wdata,
   output logic [BYTE_W-1:0]         host_rdata,
   input  logic                      pal_alt,
   input  logic [IDX_W-1:0]          pix_idx,
   output logic [COMP_N*BYTE_W-1:0]  pix_rgb
);

   localparam int ENTRY_W = COMP_N * BYTE_W;
   localparam int SEQ_N   = 2;   // 0: read side, 1: write side

   generate
      if (IDX_W > BYTE_W) begin : g_bad_idx
         $error("IDX_W must not exceed the host byte width");
      end
      if (ALT_W < 1 || ALT_W >= IDX_W) begin : g_bad_alt
         $error("ALT_W must lie between 1 and IDX_W-1");
      end
   endgenerate

   port_e              port;
   logic               alt_on;
   logic [SEQ_N-1:0]   seq_load;
   logic [SEQ_N-1:0]   seq_step;
   logic [IDX_W-1:0]   seq_idx  [SEQ_N];
   comp_e              seq_comp [SEQ_N];
   logic [IDX_W-1:0]   rd_idx;
   logic [IDX_W-1:0]   wr_idx;
   comp_e              rd_comp;
   comp_e              wr_comp;
   logic [1:0]         state_q;
   logic               commit;
   logic [ENTRY_W-1:0] stage_entry;
   logic [ENTRY_W-1:0] host_entry;

   assign port   = port_e'(host_addr);
   assign alt_on = ALT_EN ? pal_alt : 1'b0;

   assign seq_load[0] = host_wr && (port == PORT_RIDX);
   assign seq_load[1] = host_wr && (port == PORT_WIDX);
   assign seq_step[0] = host_rd && (port == PORT_DATA);
   assign seq_step[1] = host_wr && (port == PORT_DATA);

   genvar g;
   generate
      for (g = 0; g < SEQ_N; g++) begin : g_seq
         pal_index_seq #(
            .IDX_W (IDX_W),
            .ALT_W (ALT_W)
         ) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (seq_load[g]),
            .load_val (host_wdata[IDX_W-1:0]),
            .step     (seq_step[g]),
            .alt      (alt_on),
            .idx      (seq_idx[g]),
            .comp     (seq_comp[g])
         );
      end
   endgenerate

   assign rd_idx  = seq_idx[0];
   assign wr_idx  = seq_idx[1];
   assign rd_comp = seq_comp[0];
   assign wr_comp = seq_comp[1];

   pal_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (seq_step[1]),
      .comp   (wr_comp),
      .wdata  (host_wdata),
      .commit (commit),
      .entry  (stage_entry)
   );

   pal_store #(
      .IDX_W   (IDX_W),
      .ALT_W   (ALT_W),
      .ENTRY_W (ENTRY_W),
      .ALT_EN  (ALT_EN)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (commit),
      .walt    (alt_on),
      .waddr   (wr_idx),
      .wentry  (stage_entry),
      .ralt    (alt_on),
      .raddr   (rd_idx),
      .rentry  (host_entry),
      .pix_idx (pix_idx),
      .pix_rgb (pix_rgb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           state_q <= LAST_WAS_WIDX;
      else if (seq_load[0]) state_q <= LAST_WAS_RIDX;
      else if (seq_load[1]) state_q <= LAST_WAS_WIDX;
   end

   function automatic logic [BYTE_W-1:0] pick_byte(input logic [ENTRY_W-1:0] e,
                                                   input comp_e c);
      unique case (c)
         COMP_R:  return e[3*BYTE_W-1 -: BYTE_W];
         COMP_G:  return e[2*BYTE_W-1 -: BYTE_W];
         default: return e[BYTE_W-1:0];
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_rd) begin
         unique case (port)
            PORT_RIDX: host_rdata <= {{(BYTE_W-2){1'b0}}, state_q};
            PORT_DATA: host_rdata <= pick_byte(host_entry, rd_comp);
            default:   host_rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/pal_dac_port_chk.sv
`timescale 1ns/1ps
module pal_dac_port_chk #(
   parameter int IDX_W  = 8,
   parameter int ALT_W  = 3,
   parameter bit ALT_EN = 1'b1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic             host_rd,
   input logic [1:0]       host_addr,
   input logic [7:0]       host_wdata,
   input logic [7:0]       host_rdata,
   input logic             pal_alt,
   input logic [IDX_W-1:0] pix_idx,
   input logic [23:0]      pix_rgb,
   input logic [IDX_W-1:0] rd_idx,
   input logic [IDX_W-1:0] wr_idx,
   input logic [1:0]       rd_comp,
   input logic [1:0]       wr_comp
);

   logic blue_wr;
   logic blue_rd;
   assign blue_wr = host_wr && host_addr == 2'd2 && wr_comp == 2'd2;
   assign blue_rd = host_rd && host_addr == 2'd2 && rd_comp == 2'd2;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_rd)); // R5

   AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr == 2'd0 |=>
         host_rdata[7:2] == 6'd0 && host_rdata[1] == host_rdata[0]); // R2

   AST_STATE_RIDX: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr == 2'd0 && $past(host_wr && host_addr == 2'd0) |=>
         host_rdata == 8'h03); // R2

   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == 2'd0 |=>
         rd_comp == 2'd0 && rd_idx == $past(host_wdata[IDX_W-1:0])); // R6

   AST_COMP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_comp != 2'd3 && wr_comp != 2'd3); // R6

   AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      blue_wr && !(ALT_EN && pal_alt) |=>
         wr_comp == 2'd0 && wr_idx == $past(wr_idx) + 1'b1); // R3

   AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      blue_rd && !(ALT_EN && pal_alt) |=>
         rd_comp == 2'd0 && rd_idx == $past(rd_idx) + 1'b1); // R5

   AST_ALT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      blue_wr && ALT_EN && pal_alt |=>
         wr_idx[ALT_W-1:0] == $past(wr_idx[ALT_W-1:0]) + 1'b1); // R8

   AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(blue_wr) && $stable(pix_idx) |=> $stable(pix_rgb)); // R4

endmodule

bind pal_dac_port pal_dac_port_chk #(
   .IDX_W  (IDX_W),
   .ALT_W  (ALT_W),
   .ALT_EN (ALT_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .pal_alt    (pal_alt),
   .pix_idx    (pix_idx),
   .pix_rgb    (pix_rgb),
   .rd_idx     (rd_idx),
   .wr_idx     (wr_idx),
   .rd_comp    (rd_comp),
   .wr_comp    (wr_comp)
);

// File: tb/pal_dac_port_tb.sv
`timescale 1ns/1ps
module pal_dac_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [7:0]  host_wdata = 8'd0;
   logic [7:0]  host_rdata;
   logic        pal_alt = 1'b0;
   logic [7:0]  pix_idx = 8'd0;
   logic [23:0] pix_rgb;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pal_dac_port u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .pal_alt    (pal_alt),
      .pix_idx    (pix_idx),
      .pix_rgb    (pix_rgb)
   );

   // vector: {is_read, addr[1:0], wdata[7:0], expected read byte[7:0]}
   localparam int NVEC = 16;
   localparam logic [18:0] VEC [NVEC] = '{
      {1'b0, 2'd1, 8'h10, 8'h00},
      {1'b1, 2'd0, 8'h00, 8'h00},
      {1'b0, 2'd2, 8'hA1, 8'h00},
      {1'b0, 2'd2, 8'hA2, 8'h00},
      {1'b0, 2'd2, 8'hA3, 8'h00},
      {1'b0, 2'd2, 8'hB1, 8'h00},
      {1'b0, 2'd2, 8'hB2, 8'h00},
      {1'b0, 2'd2, 8'hB3, 8'h00},
      {1'b0, 2'd0, 8'h10, 8'h00},
      {1'b1, 2'd0, 8'h00, 8'h03},
      {1'b1, 2'd2, 8'h00, 8'hA1},
      {1'b1, 2'd2, 8'h00, 8'hA2},
      {1'b1, 2'd2, 8'h00, 8'hA3},
      {1'b1, 2'd2, 8'h00, 8'hB1},
      {1'b1, 2'd2, 8'h00, 8'hB2},
      {1'b1, 2'd2, 8'h00, 8'hB3}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic pix(input logic [7:0] p, output logic [23:0] c);
      @(negedge clk);
      pix_idx = p;
      @(negedge clk);
      c = pix_rgb;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0]  b;
      logic [23:0] c;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 rdata after reset", {24'd0, host_rdata}, 32'h0);
      check("R1 pixel after reset", {8'd0, pix_rgb}, 32'h0);
      rd(2'd0, b);
      check("R1 state after reset", {24'd0, b}, 32'h0);
      rd(2'd2, b);
      check("R1 entry 0 red after reset", {24'd0, b}, 32'h0);

      // vector table: R2 R3 R5
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][18]) begin
            rd(VEC[i][17:16], b);
            check($sformatf("R2 R3 R5 vector %0d", i), {24'd0, b}, {24'd0, VEC[i][7:0]});
         end else begin
            wr(VEC[i][17:16], VEC[i][15:8]);
         end
      end

      // R4: partial entry not visible
      wr(2'd1, 8'd5);
      wr(2'd2, 8'h11);
      wr(2'd2, 8'h22);
      pix(8'd5, c);
      check("R4 entry hidden before blue", {8'd0, c}, 32'h0);
      wr(2'd2, 8'h33);
      pix(8'd5, c);
      check("R4 entry stored on blue", {8'd0, c}, 32'h112233);

      // R6: index reload restarts sequence
      wr(2'd1, 8'd6);
      wr(2'd2, 8'h44);
      wr(2'd1, 8'd6);
      wr(2'd2, 8'h55);
      wr(2'd2, 8'h66);
      wr(2'd2, 8'h77);
      pix(8'd6, c);
      check("R6 write restart", {8'd0, c}, 32'h556677);
      wr(2'd0, 8'h10);
      rd(2'd2, b);
      wr(2'd0, 8'h10);
      rd(2'd2, b);
      check("R6 read restart", {24'd0, b}, 32'hA1);

      // R7: wrap 255 -> 0
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'hC1); wr(2'd2, 8'hC2); wr(2'd2, 8'hC3);
      wr(2'd2, 8'hD1); wr(2'd2, 8'hD2); wr(2'd2, 8'hD3);
      pix(8'hFF, c);
      check("R7 entry 255", {8'd0, c}, 32'hC1C2C3);
      pix(8'h00, c);
      check("R7 write wrap to 0", {8'd0, c}, 32'hD1D2D3);
      wr(2'd0, 8'hFF);
      rd(2'd2, b); rd(2'd2, b); rd(2'd2, b);
      check("R7 blue of 255", {24'd0, b}, 32'hC3);
      rd(2'd2, b);
      check("R7 read wrap to 0", {24'd0, b}, 32'hD1);

      // R8: alternate bank
      @(negedge clk); pal_alt = 1'b1;
      wr(2'd1, 8'h0F);
      wr(2'd2, 8'hE1); wr(2'd2, 8'hE2); wr(2'd2, 8'hE3);
      wr(2'd2, 8'hF1); wr(2'd2, 8'hF2); wr(2'd2, 8'hF3);
      wr(2'd0, 8'h07);
      rd(2'd2, b); check("R8 alt 7 red", {24'd0, b}, 32'hE1);
      rd(2'd2, b); check("R8 alt 7 green", {24'd0, b}, 32'hE2);
      rd(2'd2, b); check("R8 alt 7 blue", {24'd0, b}, 32'hE3);
      rd(2'd2, b); check("R8 alt wrap red", {24'd0, b}, 32'hF1);
      rd(2'd2, b); rd(2'd2, b);
      check("R8 alt wrap blue", {24'd0, b}, 32'hF3);
      pix(8'h0F, c);
      check("R8 std 15 untouched", {8'd0, c}, 32'h0);
      pix(8'h00, c);
      check("R8 std 0 untouched", {8'd0, c}, 32'hD1D2D3);
      @(negedge clk); pal_alt = 1'b0;
      wr(2'd0, 8'h00);
      rd(2'd2, b);
      check("R8 std bank back", {24'd0, b}, 32'hD1);

      // R2: state follows last index write; R5: unused ports read 0
      wr(2'd1, 8'h20);
      rd(2'd0, b);
      check("R2 state after write index", {24'd0, b}, 32'h00);
      rd(2'd1, b);
      check("R5 write index port reads 0", {24'd0, b}, 32'h00);
      rd(2'd3, b);
      check("R5 unused port reads 0", {24'd0, b}, 32'h00);

      // R9: one-clock lookup latency
      pix(8'h10, c);
      check("R9 pixel 16", {8'd0, c}, 32'hA1A2A3);
      @(negedge clk);
      pix_idx = 8'h11;
      #5;
      check("R9 no change before edge", {8'd0, pix_rgb}, 32'hA1A2A3);
      @(negedge clk);
      check("R9 pixel 17 after edge", {8'd0, pix_rgb}, 32'hB1B2B3);

      finish_run();
   end

endmodule